// File: doc/BRIEF.md
# Slow-to-Fast Ratio FIFO

This block carries data words from a slow clock domain into a fast clock domain through a small queue. The slow clock is derived from the fast clock by an integer divider, and the two clocks rise together once per slow period. The writer runs on the slow clock and the reader on the fast clock. The two clocks come from one oscillator, so no metastability synchronizer is needed. Pointer updates cross between the domains only at edges known to be safe. A strobe from the divider marks the first fast cycle after each slow rising edge. The fast side takes the new write pointer only in that cycle. The slow side takes the read pointer on its own edge.

A producer presents a word with a valid flag and must hold it while the full flag is high. A consumer sees the head word on the read data port whenever the empty flag is low, and removes it by raising ready. Both domain resets empty the queue. Both must be released before any transfer starts.

Top module: `ratio_fifo_s2f`

## Requirements
- R1: After reset, wr_full is 0 and rd_empty is 1.
- R2: The queue holds at most 2^ADDR_W words (2 by default). wr_full is 1 right after the slow edge that stores the last free entry.
- R3: A write attempted while wr_full is 1 stores nothing, and the queue contents and order are unchanged.
- R4: A read attempted while rd_empty is 1 removes nothing. rd_empty stays 1, and the next written word is the next one read.
- R5: slow_tick is high for exactly the fast cycle that starts at each slow rising edge. A word written at a slow edge leaves rd_empty at 1 during that strobe cycle and clears it from the following fast cycle.
- R6: A freed entry becomes visible to the slow side at the first slow edge strictly after the dequeuing fast edge. A dequeue on the fast edge that coincides with a slow edge frees wr_full only at the slow edge after that.
- R7: While rd_empty is 0, rd_data shows the oldest unread word with no read latency (first-word-fall-through).
- R8: The fast side updates its copy of the write pointer only in cycles where slow_tick is 1. With slow_tick held at 0, written words never reach the read side.
- R9: Every accepted word is delivered exactly once, intact and in write order, for any mix of write gaps and read stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast (reader) clock |
| rst_fast_n | input | 1 | Active-low asynchronous reset, fast domain |
| clk_slow | input | 1 | Slow (writer) clock, integer division of clk_fast |
| rst_slow_n | input | 1 | Active-low asynchronous reset, slow domain |
| slow_tick | input | 1 | Divider strobe: high in the fast cycle starting at each slow edge |
| wr_valid | input | 1 | Producer offers wr_data on the next slow edge |
| wr_data | input | DATA_W | Word to enqueue |
| wr_full | output | 1 | No free entry as seen by the slow side |
| rd_ready | input | 1 | Consumer takes the head word on the next fast edge |
| rd_data | output | DATA_W | Head word, valid while rd_empty is 0 |
| rd_empty | output | 1 | No readable word as seen by the fast side |

## Verification
On every cycle, the assertions check the following. A full write and an empty read leave their pointers untouched. Neither side ever counts more than the queue depth between its pointers. The fast copy of the write pointer moves only under the strobe, and a successful write advances the write pointer by exactly one. The bench scenarios cover the rest. They show the exact fast cycle in which a new word becomes readable, and the slow edge at which a freed entry is reused, including a dequeue on a coinciding edge. They also show the effect of a suppressed strobe and end-to-end data order across varied producer and consumer rates.

// File: rtl/ratio_fifo_pkg.sv
`timescale 1ns/1ps
package ratio_fifo_pkg;
    localparam int unsigned RF_DATA_W = 32;
    localparam int unsigned RF_ADDR_W = 1;
endpackage

// File: rtl/ratio_fifo_store.sv
`timescale 1ns/1ps
module ratio_fifo_store #(
    parameter int unsigned DATA_W = ratio_fifo_pkg::RF_DATA_W,
    parameter int unsigned ADDR_W = ratio_fifo_pkg::RF_ADDR_W
) (
    input  logic              clk_slow,
    input  logic              rst_slow_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] ent_d [DEPTH];
    logic [DATA_W-1:0] ent_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        always_comb begin
            ent_d[i] = ent_q[i];
            if (we && (waddr == ADDR_W'(i))) ent_d[i] = wdata;
        end

        always_ff @(posedge clk_slow or negedge rst_slow_n) begin
            if (!rst_slow_n) ent_q[i] <= '0;
            else             ent_q[i] <= ent_d[i];
        end
    end

    assign rdata = ent_q[raddr];
endmodule

// File: rtl/ratio_fifo_wr.sv
`timescale 1ns/1ps
module ratio_fifo_wr #(
    parameter int unsigned ADDR_W = ratio_fifo_pkg::RF_ADDR_W
) (
    input  logic            clk_slow,
    input  logic            rst_slow_n,
    input  logic            wr_valid,
    input  logic [ADDR_W:0] rptr_fast,
    output logic [ADDR_W:0] wptr,
    output logic            wr_en,
    output logic            wr_full
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PTR_W = ADDR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rseen;
    } wr_state_t;

    wr_state_t st_d, st_q;
    logic [PTR_W-1:0] wr_occ;

    always_comb begin
        wr_full = (st_q.wptr[ADDR_W-1:0] == st_q.rseen[ADDR_W-1:0]) &&
                  (st_q.wptr[ADDR_W] != st_q.rseen[ADDR_W]);
        wr_en   = wr_valid && !wr_full;
        st_d       = st_q;
        st_d.wptr  = st_q.wptr + PTR_W'(wr_en);
        st_d.rseen = rptr_fast;
    end

    always_ff @(posedge clk_slow or negedge rst_slow_n) begin
        if (!rst_slow_n) st_q <= '0;
        else             st_q <= st_d;
    end

    assign wptr   = st_q.wptr;
    assign wr_occ = st_q.wptr - st_q.rseen;

    assert_no_overflow_R3: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
        (wr_valid && wr_full) |=> $stable(st_q.wptr));

    assert_wr_span_R2: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
        wr_occ <= PTR_W'(DEPTH));

    assert_wr_step_R9: assert property (@(posedge clk_slow) disable iff (!rst_slow_n)
        (wr_valid && !wr_full) |=> (st_q.wptr == $past(st_q.wptr) + PTR_W'(1)));
endmodule

// File: rtl/ratio_fifo_rd.sv
`timescale 1ns/1ps
module ratio_fifo_rd #(
    parameter int unsigned ADDR_W = ratio_fifo_pkg::RF_ADDR_W
) (
    input  logic            clk_fast,
    input  logic            rst_fast_n,
    input  logic            slow_tick,
    input  logic            rd_ready,
    input  logic [ADDR_W:0] wptr_slow,
    output logic [ADDR_W:0] rptr,
    output logic            rd_empty
);
    localparam int unsigned DEPTH = 1 << ADDR_W;
    localparam int unsigned PTR_W = ADDR_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] rptr;
        logic [PTR_W-1:0] wseen;
    } rd_state_t;

    rd_state_t st_d, st_q;
    logic pop;
    logic [PTR_W-1:0] rd_occ;

    always_comb begin
        rd_empty = (st_q.rptr == st_q.wseen);
        pop      = rd_ready && !rd_empty;
        st_d      = st_q;
        st_d.rptr = st_q.rptr + PTR_W'(pop);
        if (slow_tick) st_d.wseen = wptr_slow;
    end

    always_ff @(posedge clk_fast or negedge rst_fast_n) begin
        if (!rst_fast_n) st_q <= '0;
        else             st_q <= st_d;
    end

    assign rptr   = st_q.rptr;
    assign rd_occ = st_q.wseen - st_q.rptr;

    assert_no_underflow_R4: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        (rd_ready && rd_empty) |=> $stable(st_q.rptr));

    assert_wptr_hold_R8: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        !slow_tick |=> $stable(st_q.wseen));

    assert_rd_span_R2: assert property (@(posedge clk_fast) disable iff (!rst_fast_n)
        rd_occ <= PTR_W'(DEPTH));
endmodule

// File: rtl/ratio_fifo_s2f.sv
`timescale 1ns/1ps
module ratio_fifo_s2f #(
    parameter int unsigned DATA_W = ratio_fifo_pkg::RF_DATA_W,
    parameter int unsigned ADDR_W = ratio_fifo_pkg::RF_ADDR_W
) (
    input  logic              clk_fast,
    input  logic              rst_fast_n,
    input  logic              clk_slow,
    input  logic              rst_slow_n,
    input  logic              slow_tick,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              rd_ready,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_empty
);
    localparam int unsigned PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wptr;
    logic [PTR_W-1:0] rptr;
    logic             wr_en;

    ratio_fifo_wr #(.ADDR_W(ADDR_W)) u_wr (
        .clk_slow  (clk_slow),
        .rst_slow_n(rst_slow_n),
        .wr_valid  (wr_valid),
        .rptr_fast (rptr),
        .wptr      (wptr),
        .wr_en     (wr_en),
        .wr_full   (wr_full)
    );

    ratio_fifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
        .clk_slow  (clk_slow),
        .rst_slow_n(rst_slow_n),
        .we        (wr_en),
        .waddr     (wptr[ADDR_W-1:0]),
        .wdata     (wr_data),
        .raddr     (rptr[ADDR_W-1:0]),
        .rdata     (rd_data)
    );

    ratio_fifo_rd #(.ADDR_W(ADDR_W)) u_rd (
        .clk_fast  (clk_fast),
        .rst_fast_n(rst_fast_n),
        .slow_tick (slow_tick),
        .rd_ready  (rd_ready),
        .wptr_slow (wptr),
        .rptr      (rptr),
        .rd_empty  (rd_empty)
    );
endmodule

// File: tb/ratio_fifo_s2f_test.sv
`timescale 1ns/1ps
module ratio_fifo_s2f_test;
    localparam int RATIO = 13;
    localparam int NW    = 24;

    logic clk_f = 0, clk_s = 0, rst_f_n = 0, rst_s_n = 0;
    logic tick = 0, tick_en = 1;
    logic wr_valid = 0, rd_ready = 0;
    logic [31:0] wr_data = '0;
    logic wr_full, rd_empty;
    logic [31:0] rd_data;
    int checks = 0, fails = 0;

    ratio_fifo_s2f uut (
        .clk_fast(clk_f), .rst_fast_n(rst_f_n), .clk_slow(clk_s), .rst_slow_n(rst_s_n),
        .slow_tick(tick), .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(wr_full),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_empty(rd_empty)
    );

    // 200 MHz fast clock; slow clock rises with every RATIO-th fast rising edge
    initial begin
        forever begin
            for (int h = 0; h < 2 * RATIO; h++) begin
                #2.5;
                clk_f = ~clk_f;
                if (h == 0)     clk_s = 1;
                if (h == RATIO) clk_s = 0;
                if (h == 1)     tick = tick_en;
                if (h == 3)     tick = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic logic [31:0] word_of(input int p, input int i);
        return 32'hA5C3_0000 ^ (32'(p) << 24) ^ (32'(i) * 32'h0001_9E37);
    endfunction

    function automatic bit take(input int p, input int c);
        case (p)
            0: return 1'b1;
            1: return (c % 3) == 0;
            2: return (c % 17) == 0;
            default: return (c % 29) < 2;
        endcase
    endfunction

    function automatic bit gap(input int p, input int sc);
        case (p)
            1: return (sc % 2) == 1;
            3: return (sc % 3) == 1;
            default: return 1'b0;
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        bit bad;
        repeat (3) @(negedge clk_s);
        @(negedge clk_f);
        rst_f_n = 1; rst_s_n = 1;
        @(negedge clk_f);
        check(wr_full == 1'b0, "R1 wr_full after reset", 32'(wr_full), 0);
        check(rd_empty == 1'b1, "R1 rd_empty after reset", 32'(rd_empty), 1);

        // R5/R7: single word visibility timing
        @(negedge clk_s); wr_valid = 1; wr_data = 32'h1111_0001;
        @(posedge clk_s); @(negedge clk_f);
        wr_valid = 0;
        check(rd_empty == 1'b1, "R5 empty during strobe cycle", 32'(rd_empty), 1);
        @(negedge clk_f);
        check(rd_empty == 1'b0, "R5 visible after strobe", 32'(rd_empty), 0);
        check(rd_data == 32'h1111_0001, "R7 head word shown", rd_data, 32'h1111_0001);

        // R2/R3: fill, then attempt a write while full
        @(negedge clk_s);
        check(wr_full == 1'b0, "R2 one free entry", 32'(wr_full), 0);
        wr_valid = 1; wr_data = 32'h2222_0002;
        @(posedge clk_s); @(negedge clk_f);
        check(wr_full == 1'b1, "R2 full after second word", 32'(wr_full), 1);
        wr_data = 32'h3333_0003;
        @(posedge clk_s); @(negedge clk_f);
        wr_valid = 0;
        check(wr_full == 1'b1, "R3 still full", 32'(wr_full), 1);
        check(rd_data == 32'h1111_0001, "R3 head unchanged", rd_data, 32'h1111_0001);

        // R6: dequeue mid slow period
        repeat (4) @(negedge clk_f);
        rd_ready = 1;
        @(negedge clk_f); rd_ready = 0;
        check(rd_data == 32'h2222_0002, "R3 next word not overwritten", rd_data, 32'h2222_0002);
        check(wr_full == 1'b1, "R6 full until slow edge", 32'(wr_full), 1);
        @(posedge clk_s); @(negedge clk_f);
        check(wr_full == 1'b0, "R6 slot freed at next slow edge", 32'(wr_full), 0);
        @(negedge clk_s); wr_valid = 1; wr_data = 32'h4444_0004;
        @(posedge clk_s); @(negedge clk_f); wr_valid = 0;
        check(wr_full == 1'b1, "R2 refilled", 32'(wr_full), 1);

        // R6: dequeue on the edge that coincides with a slow edge
        repeat (RATIO - 1) @(negedge clk_f);
        rd_ready = 1;
        @(posedge clk_s); @(negedge clk_f); rd_ready = 0;
        check(rd_data == 32'h4444_0004, "R7 head after coincident pop", rd_data, 32'h4444_0004);
        check(wr_full == 1'b1, "R6 coincident pop not seen yet", 32'(wr_full), 1);
        @(posedge clk_s); @(negedge clk_f);
        check(wr_full == 1'b0, "R6 coincident pop seen one slow edge later", 32'(wr_full), 0);
        rd_ready = 1;
        @(negedge clk_f); rd_ready = 0;
        check(rd_empty == 1'b1, "R7 drained", 32'(rd_empty), 1);

        // R4: reads while empty
        rd_ready = 1; bad = 0;
        repeat (20) begin
            @(negedge clk_f);
            if (!rd_empty) bad = 1;
        end
        rd_ready = 0;
        check(!bad, "R4 empty held under reads", 32'(bad), 0);
        @(negedge clk_s); wr_valid = 1; wr_data = 32'h5555_0005;
        @(posedge clk_s); @(negedge clk_f); wr_valid = 0;
        @(negedge clk_f);
        check(!rd_empty && rd_data == 32'h5555_0005, "R4 next word read after underflow attempt", rd_data, 32'h5555_0005);
        rd_ready = 1; @(negedge clk_f); rd_ready = 0;

        // R8: strobe suppressed
        @(negedge clk_s); tick_en = 0; wr_valid = 1; wr_data = 32'h6666_0006;
        @(posedge clk_s); @(negedge clk_f); wr_valid = 0; bad = 0;
        repeat (30) begin
            @(negedge clk_f);
            if (!rd_empty) bad = 1;
        end
        check(!bad, "R8 word hidden without strobe", 32'(bad), 0);
        @(negedge clk_s); tick_en = 1;
        @(posedge clk_s); @(negedge clk_f);
        check(rd_empty == 1'b1, "R8 hidden until strobe cycle ends", 32'(rd_empty), 1);
        @(negedge clk_f);
        check(!rd_empty && rd_data == 32'h6666_0006, "R8 visible after strobe", rd_data, 32'h6666_0006);
        rd_ready = 1; @(negedge clk_f); rd_ready = 0;

        // R9: rate sweep
        for (int p = 0; p < 4; p++) begin
            int wn, rn;
            wn = 0; rn = 0;
            fork
                begin
                    int sc;
                    sc = 0;
                    while (wn < NW) begin
                        @(negedge clk_s);
                        sc++;
                        if (gap(p, sc)) wr_valid = 0;
                        else if (!wr_full) begin
                            wr_valid = 1; wr_data = word_of(p, wn); wn++;
                        end else begin
                            wr_valid = 1; wr_data = 32'hDEAD_BEEF;
                        end
                    end
                    @(negedge clk_s); wr_valid = 0;
                end
                begin
                    int c;
                    c = 0;
                    while (rn < NW) begin
                        @(negedge clk_f);
                        rd_ready = 0;
                        if (!rd_empty && take(p, c)) begin
                            check(rd_data == word_of(p, rn), "R9 order and data", rd_data, word_of(p, rn));
                            rd_ready = 1; rn++;
                        end
                        c++;
                    end
                    @(negedge clk_f); rd_ready = 0;
                end
            join
            repeat (2 * RATIO) @(negedge clk_f);
            check(rd_empty == 1'b1, "R9 nothing extra delivered", 32'(rd_empty), 1);
            check(wr_full == 1'b0, "R9 all slots free", 32'(wr_full), 0);
        end
        finish_run();
    end
endmodule